// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Pipeline

This block models a single-port synchronous static RAM with a built-in four-beat burst address generator. Address, the three chip enables, two address strobes, the advance input and the write controls are all captured on the rising clock edge. One strobe is meant for a processor and always starts a read. The other is meant for a cache controller and starts either a read or a write. Once an access is open, the burst generator steps through the four words of an aligned group, in linear or interleaved order, whenever advance is asserted.

Reads leave the block in one of two ways, chosen by a mode input. In flow-through mode the array output goes straight to the data pins in the cycle after capture. In pipelined mode it passes through one more output register. The output drive follows a single-cycle-deselect rule: it stops as soon as a deselect has been captured. Output enable and the sleep request act asynchronously on the drive. Sleep also freezes the command path while the array keeps its contents.

Writes are byte-masked through a lane-write enable and per-lane selects, or global through a separate write-all input.

Top module: `burst_sram`

## Requirements
- R1: With `pipe_mode`=0 (flow-through), read data for a read captured at edge N is on `q_out` with `q_drive`=1 in the cycle after edge N. `q_drive` is 0 in any cycle whose last captured command was not a read.
- R2: With `pipe_mode`=1 (pipelined), read data for a read captured at edge N appears after edge N+1. In the cycle right after N, the drive comes only from an earlier read.
- R3: The burst offset is held in address bits [1:0]. With `lin_order`=1 the k-th word uses (base+k) mod 4; with `lin_order`=0 it uses base XOR k. The upper address bits stay fixed, and the fifth word wraps to the base.
- R4: With no strobe and `step_n`=1 during an open access, the address holds and the same word is accessed again.
- R5: With `lane_wr_n`=0 and `all_wr_n`=1, lane i (bits 8i+7:8i) is written only when `lane_sel_n[i]`=0, and the other lanes keep their contents. With every select high, nothing is written.
- R6: `all_wr_n`=0 writes all four lanes, whatever `lane_wr_n` and `lane_sel_n` are.
- R7: `proc_strb_n`=0 with `en_a_n`=0 starts a read at `addr`, ignores the write controls, and takes priority over `ctl_strb_n`. `proc_strb_n` is masked while `en_a_n`=1. `ctl_strb_n`=0 starts a read or a write. A strobe with any enable inactive (`en_a_n`=1, `en_b`=0 or `en_c_n`=1) deselects the device.
- R8: `en_b` and `en_c_n` are ignored on cycles without an active strobe, so a running burst continues.
- R9: With `pipe_mode`=1, a deselect captured at edge N turns `q_drive` off right after N, even though a read was captured at N-1.
- R10: `out_en_n`=1 forces `q_drive` to 0 within the same cycle, and the drive returns when it falls.
- R11: `sleep_req`=1 forces `q_drive` to 0 at once. Commands, including writes, are ignored while it is high. The array contents are kept, and the device is deselected afterwards.
- R12: Synchronous `rst` leaves the device deselected with `q_drive`=0.
- R13: A read captured in the cycle after a write to the same address returns the newly written word in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 6 | Word address |
| en_a_n | input | 1 | Chip enable, active low; also masks the processor strobe |
| en_b | input | 1 | Chip enable, active high, looked at only with a strobe |
| en_c_n | input | 1 | Chip enable, active low, looked at only with a strobe |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| d_in | input | 32 | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| q_out | output | 32 | Read data |
| q_drive | output | 1 | Tri-state enable for `q_out` |

## Verification
The bench builds the block with its defaults: a 32-bit word in four 8-bit lanes and a 64-word array. The six-bit address leaves four upper bits, so bursts in both orders can start at unaligned offsets in several separate four-word groups. Because the array is small, a shadow copy mirrors all of it. Byte-mask merges, global-write overrides, read-after-write and mid-burst deselects can then be compared word for word in both read modes.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int unsigned BURST_W = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    typedef struct packed {
        acc_e kind;
        logic load;
        logic advance;
    } cmd_t;

    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] step,
        input logic               linear
    );
        return linear ? (base + step) : (base ^ step);
    endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             en_a_n,
    input  logic             en_b,
    input  logic             en_c_n,
    input  logic             proc_strb_n,
    input  logic             ctl_strb_n,
    input  logic             step_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    output cmd_t             cmd,
    output logic [LANES-1:0] lane_we,
    output acc_e             cur_kind
);

    logic             p_start;
    logic             c_start;
    logic             sel_ok;
    logic             wr_req;
    logic [LANES-1:0] wr_mask;

    always_comb begin
        p_start = !proc_strb_n && !en_a_n;
        c_start = !p_start && !ctl_strb_n;
        sel_ok  = !en_a_n && en_b && !en_c_n;
        wr_mask = !all_wr_n ? {LANES{1'b1}} :
                  (!lane_wr_n ? ~lane_sel_n : {LANES{1'b0}});
        wr_req  = (wr_mask != '0);

        cmd.kind    = ACC_IDLE;
        cmd.load    = 1'b0;
        cmd.advance = 1'b0;
        if (sleep_req) begin
            cmd.kind = ACC_IDLE;
        end else if (p_start) begin
            if (sel_ok) begin
                cmd.kind = ACC_READ;
                cmd.load = 1'b1;
            end
        end else if (c_start) begin
            if (sel_ok) begin
                cmd.kind = wr_req ? ACC_WRITE : ACC_READ;
                cmd.load = 1'b1;
            end
        end else if (cur_kind != ACC_IDLE) begin
            cmd.kind    = wr_req ? ACC_WRITE : ACC_READ;
            cmd.advance = !step_n;
        end

        lane_we = (cmd.kind == ACC_WRITE) ? wr_mask : {LANES{1'b0}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_kind <= ACC_IDLE;
        end else begin
            cur_kind <= cmd.kind;
        end
    end

    AST_PSTART_READS: assert property (@(posedge clk) disable iff (rst)
        (!proc_strb_n && !en_a_n && !sleep_req) |-> (lane_we == '0)); // R7

endmodule

// File: rtl/burst_sram_burst.sv
module burst_sram_burst
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic              linear,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] eff_addr
);

    localparam int unsigned UP_W = ADDR_W - BURST_W;

    logic [UP_W-1:0]    upper_q;
    logic [BURST_W-1:0] base_q;
    logic [BURST_W-1:0] step_q;
    logic [BURST_W-1:0] step_use;

    always_comb begin
        step_use = advance ? (step_q + 1'b1) : step_q;
        if (load) begin
            eff_addr = addr_in;
        end else begin
            eff_addr = {upper_q, burst_offset(base_q, step_use, linear)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            base_q  <= '0;
            step_q  <= '0;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:BURST_W];
            base_q  <= addr_in[BURST_W-1:0];
            step_q  <= '0;
        end else if (advance) begin
            step_q  <= step_q + 1'b1;
        end
    end

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (advance && !load) |=> (step_q == $past(step_q) + 1'b1)); // R3

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!advance && !load) |=> ($stable(step_q) && $stable(base_q))); // R4

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned LANES  = DATA_W / LANE_W,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned LANES  = DATA_W / LANE_W,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              proc_strb_n,
    input  logic              ctl_strb_n,
    input  logic              step_n,
    input  logic              all_wr_n,
    input  logic              lane_wr_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic [DATA_W-1:0] d_in,
    input  logic              out_en_n,
    input  logic              sleep_req,
    input  logic              pipe_mode,
    input  logic              lin_order,
    output logic [DATA_W-1:0] q_out,
    output logic              q_drive
);

    cmd_t              cmd;
    logic [LANES-1:0]  lane_we;
    acc_e              cur_kind;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] s2_data;
    logic              s2_rd;
    logic              path_en;

    burst_sram_ctrl #(.LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .en_a_n     (en_a_n),
        .en_b       (en_b),
        .en_c_n     (en_c_n),
        .proc_strb_n(proc_strb_n),
        .ctl_strb_n (ctl_strb_n),
        .step_n     (step_n),
        .all_wr_n   (all_wr_n),
        .lane_wr_n  (lane_wr_n),
        .lane_sel_n (lane_sel_n),
        .cmd        (cmd),
        .lane_we    (lane_we),
        .cur_kind   (cur_kind)
    );

    burst_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk     (clk),
        .rst     (rst),
        .load    (cmd.load),
        .advance (cmd.advance),
        .linear  (lin_order),
        .addr_in (addr),
        .eff_addr(eff_addr)
    );

    burst_sram_array #(.DATA_W(DATA_W), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_array (
        .clk    (clk),
        .lane_we(lane_we),
        .wr_addr(eff_addr),
        .wr_data(d_in),
        .rd_addr(s1_addr),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_addr <= '0;
            s2_data <= '0;
            s2_rd   <= 1'b0;
        end else begin
            if (cmd.kind != ACC_IDLE) begin
                s1_addr <= eff_addr;
            end
            s2_data <= rd_data;
            s2_rd   <= (cur_kind == ACC_READ);
        end
    end

    always_comb begin
        if (pipe_mode) begin
            q_out   = s2_data;
            path_en = s2_rd && (cur_kind != ACC_IDLE);
        end else begin
            q_out   = rd_data;
            path_en = (cur_kind == ACC_READ);
        end
        q_drive = path_en && !out_en_n && !sleep_req;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !q_drive); // R12

    AST_FT_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && cmd.kind != ACC_READ) |=> (pipe_mode || !q_drive)); // R1

    AST_SCD_OFF: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && cmd.kind == ACC_IDLE) |=> (!pipe_mode || !q_drive)); // R9

    AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> (lane_we == '0)); // R11

    AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (rst)
        (!all_wr_n && lane_we != '0) |-> (&lane_we)); // R6

endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

    localparam int unsigned DW = 32;
    localparam int unsigned AW = 6;
    localparam int unsigned NV = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          en_a_n, en_b, en_c_n;
    logic          proc_strb_n, ctl_strb_n, step_n;
    logic          all_wr_n, lane_wr_n;
    logic [3:0]    lane_sel_n;
    logic [DW-1:0] d_in;
    logic          out_en_n, sleep_req, pipe_mode, lin_order;
    logic [DW-1:0] q_out;
    logic          q_drive;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic [DW-1:0] sh [64];

    // vector fields: {global(1), lane_sel_n(4), addr(6), data(32)}
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 4'b1110, 6'd3,  32'hDEAD_BE01},
        {1'b0, 4'b0101, 6'd12, 32'h1122_3344},
        {1'b1, 4'b1111, 6'd5,  32'hCAFE_F00D},
        {1'b0, 4'b1111, 6'd7,  32'h9999_9999},
        {1'b0, 4'b0000, 6'd14, 32'h0BAD_C0DE},
        {1'b1, 4'b0000, 6'd2,  32'h5A5A_A5A5},
        {1'b0, 4'b0111, 6'd3,  32'h77AB_CDEF},
        {1'b0, 4'b1001, 6'd12, 32'hFF00_FF00}
    };

    always #10 clk = ~clk;

    burst_sram u_burst_sram (
        .clk(clk), .rst(rst), .addr(addr), .en_a_n(en_a_n), .en_b(en_b),
        .en_c_n(en_c_n), .proc_strb_n(proc_strb_n), .ctl_strb_n(ctl_strb_n),
        .step_n(step_n), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
        .lane_sel_n(lane_sel_n), .d_in(d_in), .out_en_n(out_en_n),
        .sleep_req(sleep_req), .pipe_mode(pipe_mode), .lin_order(lin_order),
        .q_out(q_out), .q_drive(q_drive)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic see_data(input string req, input logic [DW-1:0] exp);
        chk(q_drive === 1'b1, req, {31'd0, q_drive}, 32'd1);
        chk(q_out === exp, req, q_out, exp);
    endtask

    task automatic see_off(input string req);
        chk(q_drive === 1'b0, req, {31'd0, q_drive}, 32'd0);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        proc_strb_n = 1'b1; ctl_strb_n = 1'b1; step_n = 1'b1;
        all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = 4'hF;
        en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic gw, input logic lw, input logic [3:0] sel);
        quiet();
        ctl_strb_n = 1'b0; addr = a; d_in = d;
        all_wr_n = !gw; lane_wr_n = !lw; lane_sel_n = sel;
        for (int i = 0; i < 4; i++) begin
            if (gw || (lw && !sel[i])) sh[a][i*8 +: 8] = d[i*8 +: 8];
        end
        tick();
        quiet();
    endtask

    task automatic rd(input logic [AW-1:0] a);
        quiet();
        ctl_strb_n = 1'b0; addr = a;
        tick();
        quiet();
    endtask

    task automatic desel();
        quiet();
        ctl_strb_n = 1'b0; en_a_n = 1'b1;
        tick();
        quiet();
    endtask

    task automatic cont(input logic adv);
        quiet();
        step_n = !adv;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr = '0; d_in = '0; out_en_n = 1'b0; sleep_req = 1'b0;
        pipe_mode = 1'b0; lin_order = 1'b1;
        quiet();
        repeat (3) tick();
        see_off("R12 reset deselects");
        rst = 1'b0;

        // prefill with global writes
        for (int a = 0; a < 16; a++) begin
            wr(AW'(a), 32'h1000_0000 + 32'(a) * 32'h0103_0507, 1'b1, 1'b0, 4'hF);
        end

        // vector table: byte and global writes, then read-back in flow mode
        for (int v = 0; v < int'(NV); v++) begin
            wr(VEC[v][37:32], VEC[v][31:0], VEC[v][42], 1'b1, VEC[v][41:38]);
        end
        for (int v = 0; v < int'(NV); v++) begin
            rd(VEC[v][37:32]);
            see_data("R5 R6 R1 lane merge readback", sh[VEC[v][37:32]]);
        end

        // R13 flow read right after write
        wr(6'd9, 32'h0123_4567, 1'b1, 1'b0, 4'hF);
        rd(6'd9);
        see_data("R13 flow read-after-write", 32'h0123_4567);

        // R10 async output enable
        out_en_n = 1'b1; #1;
        see_off("R10 output enable high");
        out_en_n = 1'b0; #1;
        see_data("R10 output enable low", 32'h0123_4567);

        // R3 linear burst from offset 2, with R8 enables ignored mid-burst
        lin_order = 1'b1;
        rd(6'd6);
        see_data("R3 linear beat0", sh[6]);
        cont(1'b1);
        see_data("R3 linear beat1", sh[7]);
        quiet(); step_n = 1'b0; en_b = 1'b0; en_c_n = 1'b1;
        tick();
        see_data("R8 enables ignored beat2", sh[4]);
        cont(1'b1);
        see_data("R3 linear beat3", sh[5]);
        cont(1'b1);
        see_data("R3 linear wrap", sh[6]);
        cont(1'b0);
        see_data("R4 suspend holds", sh[6]);

        // R3 interleaved burst from offset 1
        lin_order = 1'b0;
        rd(6'd9);
        see_data("R3 interleave beat0", sh[9]);
        cont(1'b1);
        see_data("R3 interleave beat1", sh[8]);
        cont(1'b1);
        see_data("R3 interleave beat2", sh[11]);
        cont(1'b1);
        see_data("R3 interleave beat3", sh[10]);
        lin_order = 1'b1;

        // R1 deselect
        desel();
        see_off("R1 flow deselect off");

        // R7 processor strobe masked by en_a_n
        quiet(); proc_strb_n = 1'b0; en_a_n = 1'b1; addr = 6'd3;
        tick();
        see_off("R7 masked processor strobe");

        // R7 processor strobe ignores write controls and wins over controller strobe
        quiet(); proc_strb_n = 1'b0; ctl_strb_n = 1'b0; all_wr_n = 1'b0;
        addr = 6'd12; d_in = 32'hFFFF_FFFF;
        tick();
        see_data("R7 processor start is read", sh[12]);
        desel();
        rd(6'd12);
        see_data("R7 no write on processor start", sh[12]);

        // R7 controller strobe with en_b low deselects
        quiet(); ctl_strb_n = 1'b0; en_b = 1'b0; addr = 6'd12;
        tick();
        see_off("R7 strobe with en_b low");

        // R11 sleep
        rd(6'd5);
        see_data("R11 before sleep", sh[5]);
        sleep_req = 1'b1; #1;
        see_off("R11 sleep drive off");
        wr(6'd5, 32'h0000_0000, 1'b1, 1'b0, 4'hF);
        sh[5] = 32'hCAFE_F00D;
        sleep_req = 1'b0; #1;
        see_off("R11 deselected after sleep");
        rd(6'd5);
        see_data("R11 contents kept", 32'hCAFE_F00D);

        // pipelined mode
        desel();
        pipe_mode = 1'b1;
        rd(6'd14);
        see_off("R2 pipeline not yet");
        cont(1'b0);
        see_data("R2 pipeline data one cycle later", sh[14]);
        desel();
        see_off("R9 single-cycle deselect");

        // pipelined linear burst from offset 1
        rd(6'd1);
        cont(1'b1);
        see_data("R2 R3 pipe beat0", sh[1]);
        cont(1'b1);
        see_data("R2 R3 pipe beat1", sh[2]);
        cont(1'b1);
        see_data("R2 R3 pipe beat2", sh[3]);
        cont(1'b0);
        see_data("R2 R3 pipe beat3", sh[0]);
        desel();
        see_off("R9 deselect mid-burst");

        // R13 pipelined read-after-write
        wr(6'd13, 32'hA1B2_C3D4, 1'b0, 1'b1, 4'b0011);
        rd(6'd13);
        cont(1'b0);
        see_data("R13 pipe read-after-write", sh[13]);
        desel();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule